// File: doc/BRIEF.md
# Grouped Pin Interrupt Controller

This block watches a wide bank of already-synchronised general-purpose input pins and folds them into a single interrupt request line. Eight interrupt groups are shared across the bank. Pin number i can only ever be served by group (i mod 8). Each group has its own source-pin selector. The selector picks the port and the byte lane, and the group number fixes the bit within that lane. Each group also has a 3-bit trigger code that chooses level, edge, forced-set or off behaviour.

Software reaches the block through a flat register port with write enable, word address, write data and combinational read data. Through it, software sets the packed trigger codes, the packed pin selectors and the per-group enable mask. It clears latched edge events by writing ones to an acknowledge address. It can read both the raw and the masked group status. The request output is the registered OR of the masked status bits.

Register map (word addresses): 0 trigger codes, 1 pin selectors, 2 enable mask, 3 acknowledge (write only), 4 raw status, 5 masked status.

Top module: `gpio_grp_irq`

## Requirements
- R1: After reset, the trigger, selector and mask registers read zero, the raw and masked status read zero, and `irq_o` is 0.
- R2: Address 0 holds the trigger codes. Group g uses bits [3g+2:3g], and the register reads back what was written in bits [23:0], with upper bits zero.
- R3: Address 1 holds the selectors. Group g uses bits [4g+3:4g]. A selector value s makes group g watch bit 8*(s mod 4)+g of port s/4. Port p occupies bits [32p+31:32p] of `pins_i`. Pins that are not selected have no effect on the group.
- R4: Code 1 (level high) sets raw bit g to the selected pin level sampled at the previous clock. Code 2 (level low) sets it to the inverse of that level. An acknowledge has no lasting effect while the level persists.
- R5: Code 5 latches raw bit g on a 0-to-1 change of the selected pin between consecutive clocks, code 6 on a 1-to-0 change, and code 7 on either change. The bit is visible in the cycle after the change and stays set until acknowledged.
- R6: Writing address 3 clears latched edge status for every group whose write-data bit is 1. Bits written as 0 leave their groups untouched. A new edge in the same cycle as the acknowledge leaves the bit set.
- R7: Code 3 forces raw bit g to 1 from the cycle after it is written. Codes 0 and 4 force it to 0.
- R8: Address 2 holds the one-bit-per-group enable mask in bits [7:0]. Address 5 reads raw status AND mask in bits [7:0], with upper bits zero.
- R9: `irq_o` equals the OR of the masked status bits one clock earlier.
- R10: Reads of address 3 and of addresses 6 and above return zero. Writes to addresses 4 and above change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | NPORTS*PORT_W (128) | Synchronised input pins, port p at bits [32p+31:32p] |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW (4) | Register word address |
| wdata | input | DW (32) | Register write data |
| rdata | output | DW (32) | Combinational read data for `addr` |
| irq_o | output | 1 | Registered combined interrupt request |

## Verification
A register write takes effect at the clock edge on which `wr_en` is sampled. Raw status reflects a pin level or edge one clock edge after the pin changes. `irq_o` trails masked status by one more edge. Read data is combinational, so a read settles in the same cycle as the address. The bench drives pins and register strobes on the falling edge. It reads raw status after exactly one rising edge and reads `irq_o` after a second one. For the registered request it also samples the edge between those two, where the old value must still show, so a missing or extra register stage is caught.

// File: rtl/gpirq_pkg.sv
package gpirq_pkg;

    localparam int NGRP    = 8;
    localparam int TRIG_W  = 3;
    localparam int SEL_W   = 4;
    localparam int LANES   = 4;
    localparam int LANE_W  = 8;
    localparam int CAND_N  = 1 << SEL_W;
    localparam int CFG_BITS = NGRP * TRIG_W;
    localparam int SEL_BITS = NGRP * SEL_W;

    localparam int ADR_TRIG  = 0;
    localparam int ADR_SEL   = 1;
    localparam int ADR_MASK  = 2;
    localparam int ADR_ACK   = 3;
    localparam int ADR_RAW   = 4;
    localparam int ADR_MSKD  = 5;

    typedef enum logic [TRIG_W-1:0] {
        TRG_OFF  = 3'd0,
        TRG_HIGH = 3'd1,
        TRG_LOW  = 3'd2,
        TRG_SET  = 3'd3,
        TRG_RSV  = 3'd4,
        TRG_RISE = 3'd5,
        TRG_FALL = 3'd6,
        TRG_ANY  = 3'd7
    } trig_e;

    typedef struct packed {
        logic [CFG_BITS-1:0] trig;
        logic [SEL_BITS-1:0] sel;
        logic [NGRP-1:0]     mask;
    } ctl_s;

    function automatic logic is_edge_mode(logic [TRIG_W-1:0] t);
        return t[2] && (t[1:0] != 2'b00);
    endfunction

endpackage

// File: rtl/gpirq_regs.sv
module gpirq_regs
    import gpirq_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    input  logic [NGRP-1:0] raw_st,
    output ctl_s            ctl,
    output logic [NGRP-1:0] ack,
    output logic [DW-1:0]   rdata
);

    logic hit_trig, hit_sel, hit_mask, hit_ack;

    always_comb begin
        hit_trig = (addr == AW'(ADR_TRIG));
        hit_sel  = (addr == AW'(ADR_SEL));
        hit_mask = (addr == AW'(ADR_MASK));
        hit_ack  = (addr == AW'(ADR_ACK));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
        end else if (wr_en) begin
            if (hit_trig) ctl.trig <= wdata[CFG_BITS-1:0];
            if (hit_sel)  ctl.sel  <= wdata[SEL_BITS-1:0];
            if (hit_mask) ctl.mask <= wdata[NGRP-1:0];
        end
    end

    always_comb begin
        ack = (wr_en && hit_ack) ? wdata[NGRP-1:0] : '0;
    end

    always_comb begin
        rdata = '0;
        if (addr == AW'(ADR_TRIG))      rdata[CFG_BITS-1:0] = ctl.trig;
        else if (addr == AW'(ADR_SEL))  rdata[SEL_BITS-1:0] = ctl.sel;
        else if (addr == AW'(ADR_MASK)) rdata[NGRP-1:0]     = ctl.mask;
        else if (addr == AW'(ADR_RAW))  rdata[NGRP-1:0]     = raw_st;
        else if (addr == AW'(ADR_MSKD)) rdata[NGRP-1:0]     = raw_st & ctl.mask;
    end

endmodule

// File: rtl/gpirq_group.sv
module gpirq_group
    import gpirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CAND_N-1:0] cand,
    input  logic [SEL_W-1:0]  sel,
    input  logic [TRIG_W-1:0] trig,
    input  logic              ack,
    output logic              st
);

    logic  pin, prev, hit;
    trig_e mode;

    always_comb begin
        pin  = cand[sel];
        mode = trig_e'(trig);
        unique case (mode)
            TRG_RISE: hit = pin & ~prev;
            TRG_FALL: hit = ~pin & prev;
            TRG_ANY:  hit = pin ^ prev;
            default:  hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= 1'b0;
            st   <= 1'b0;
        end else begin
            prev <= pin;
            unique case (mode)
                TRG_HIGH: st <= pin;
                TRG_LOW:  st <= ~pin;
                TRG_SET:  st <= 1'b1;
                TRG_RISE, TRG_FALL, TRG_ANY: begin
                    if (hit)      st <= 1'b1;
                    else if (ack) st <= 1'b0;
                end
                default:  st <= 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/gpio_grp_irq.sv
module gpio_grp_irq
    import gpirq_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int PORT_W = 32,
    parameter int AW     = 4,
    parameter int DW     = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NPORTS*PORT_W-1:0] pins_i,
    input  logic                     wr_en,
    input  logic [AW-1:0]            addr,
    input  logic [DW-1:0]            wdata,
    output logic [DW-1:0]            rdata,
    output logic                     irq_o
);

    localparam int MAX_PORTS = CAND_N / LANES;

    ctl_s            ctl;
    logic [NGRP-1:0] ack;
    logic [NGRP-1:0] raw_w;
    logic [NGRP-1:0] mask_w;
    logic [CFG_BITS-1:0] trig_w;
    logic [SEL_BITS-1:0] sel_w;
    logic            irq_q;

    gpirq_regs #(.AW(AW), .DW(DW)) regs_i (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .raw_st (raw_w),
        .ctl    (ctl),
        .ack    (ack),
        .rdata  (rdata)
    );

    always_comb begin
        mask_w = ctl.mask;
        trig_w = ctl.trig;
        sel_w  = ctl.sel;
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        logic [CAND_N-1:0] cand;
        for (genvar p = 0; p < MAX_PORTS; p++) begin : g_port
            for (genvar l = 0; l < LANES; l++) begin : g_lane
                localparam int BIT = l * LANE_W + g;
                if (p < NPORTS && BIT < PORT_W) begin : g_on
                    assign cand[p*LANES + l] = pins_i[p*PORT_W + BIT];
                end else begin : g_off
                    assign cand[p*LANES + l] = 1'b0;
                end
            end
        end

        gpirq_group grp_i (
            .clk  (clk),
            .rst  (rst),
            .cand (cand),
            .sel  (ctl.sel[g*SEL_W +: SEL_W]),
            .trig (ctl.trig[g*TRIG_W +: TRIG_W]),
            .ack  (ack[g]),
            .st   (raw_w[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |(raw_w & ctl.mask);
    end

    assign irq_o = irq_q;

endmodule

// File: rtl/gpirq_chk.sv
module gpirq_chk
    import gpirq_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 32
) (
    input logic                clk,
    input logic                rst,
    input logic                wr_en,
    input logic [AW-1:0]       addr,
    input logic [NGRP-1:0]     wlow,
    input logic [DW-1:0]       rdata,
    input logic                irq_o,
    input logic [CFG_BITS-1:0] trig,
    input logic [SEL_BITS-1:0] sel,
    input logic [NGRP-1:0]     mask,
    input logic [NGRP-1:0]     raw
);

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (trig == '0 && sel == '0 && mask == '0 && raw == '0 && !irq_o));

    a_r9_irq_registered: assert property (@(posedge clk) disable iff (rst)
        irq_o == |($past(raw & mask)));

    a_r10_undef_read_zero: assert property (@(posedge clk) disable iff (rst)
        (addr == AW'(ADR_ACK) || addr > AW'(ADR_MSKD)) |-> (rdata == '0));

    a_r10_undef_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr > AW'(ADR_ACK)) |=> ($stable(trig) && $stable(sel) && $stable(mask)));

    for (genvar g = 0; g < NGRP; g++) begin : g_chk
        a_r7_set_forces_one: assert property (@(posedge clk) disable iff (rst)
            (trig[g*TRIG_W +: TRIG_W] == 3'd3) |=> raw[g]);

        a_r5_edge_hold: assert property (@(posedge clk) disable iff (rst)
            (raw[g] && is_edge_mode(trig[g*TRIG_W +: TRIG_W])
             && !(wr_en && addr == AW'(ADR_ACK) && wlow[g])
             && !(wr_en && addr == AW'(ADR_TRIG)))
            |=> raw[g]);
    end

endmodule

bind gpio_grp_irq gpirq_chk #(.AW(AW), .DW(DW)) chk_i (
    .clk   (clk),
    .rst   (rst),
    .wr_en (wr_en),
    .addr  (addr),
    .wlow  (wdata[7:0]),
    .rdata (rdata),
    .irq_o (irq_o),
    .trig  (trig_w),
    .sel   (sel_w),
    .mask  (mask_w),
    .raw   (raw_w)
);

// File: tb/gpio_grp_irq_tb.sv
`timescale 1ns/1ps
module gpio_grp_irq_tb_top;

    logic         clk = 1'b0;
    logic         rst;
    logic [127:0] pins;
    logic         wr_en;
    logic [3:0]   addr;
    logic [31:0]  wdata;
    logic [31:0]  rdata;
    logic         irq_o;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 0;

    always #5 clk = ~clk;

    gpio_grp_irq dut_i (
        .clk(clk), .rst(rst), .pins_i(pins), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
    );

    typedef struct packed {
        logic [2:0] grp;
        logic [2:0] mode;
        logic [3:0] sel;
        logic       lvl;
        logic       exp;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{3'd0, 3'd1, 4'd0,  1'b1, 1'b1},
        '{3'd1, 3'd1, 4'd5,  1'b0, 1'b0},
        '{3'd2, 3'd2, 4'd2,  1'b0, 1'b1},
        '{3'd3, 3'd2, 4'd15, 1'b1, 1'b0},
        '{3'd4, 3'd3, 4'd7,  1'b0, 1'b1},
        '{3'd5, 3'd4, 4'd13, 1'b1, 1'b0},
        '{3'd6, 3'd0, 4'd9,  1'b1, 1'b0},
        '{3'd7, 3'd1, 4'd14, 1'b1, 1'b1}
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        logic [31:0] r;
        rst = 1'b1; pins = '0; wr_en = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            rd(4'(a), r);
            check("R1 reset reg", r, 32'h0);
        end
        check("R1 reset irq", {31'b0, irq_o}, 32'h0);

        // Table walk: R2, R3, R4, R7, R9
        for (int i = 0; i < 8; i++) begin
            vec_t v;
            int   idx;
            v   = VECS[i];
            idx = int'(v.sel >> 2) * 32 + int'(v.sel & 4'd3) * 8 + int'(v.grp);
            pins = '0;
            wr(4'd0, 32'(v.mode) << (3 * v.grp));
            wr(4'd1, 32'(v.sel) << (4 * v.grp));
            wr(4'd2, 32'h1 << v.grp);
            rd(4'd0, r); check("R2 trig readback", r, 32'(v.mode) << (3 * v.grp));
            rd(4'd1, r); check("R3 sel readback", r, 32'(v.sel) << (4 * v.grp));
            pins[idx] = v.lvl;
            @(negedge clk);
            rd(4'd4, r); check("R4 R7 table raw", r, 32'(v.exp) << v.grp);
            @(negedge clk);
            check("R9 table irq", {31'b0, irq_o}, {31'b0, v.exp});
        end

        // R3 unselected pin: group 5 watches port3 lane1 bit 109, drive 110 and 101
        pins = '0;
        wr(4'd0, 32'(1) << 15);
        wr(4'd1, 32'(13) << 20);
        pins[110] = 1'b1; pins[101] = 1'b1;
        @(negedge clk); @(negedge clk);
        rd(4'd4, r); check("R3 unselected pin", r, 32'h0);
        pins[109] = 1'b1;
        @(negedge clk);
        rd(4'd4, r); check("R3 selected pin", r, 32'h20);

        // R5 rising edge on group 0, port0 bit0
        pins = '0;
        wr(4'd1, 32'h0);
        wr(4'd2, 32'h1);
        wr(4'd0, 32'd5);
        @(negedge clk);
        pins[0] = 1'b1;
        @(negedge clk);
        rd(4'd4, r); check("R5 rise latch", r, 32'h1);
        pins[0] = 1'b0;
        @(negedge clk); @(negedge clk);
        rd(4'd4, r); check("R5 rise hold", r, 32'h1);
        wr(4'd3, 32'hFE);
        rd(4'd4, r); check("R6 zero bits ignored", r, 32'h1);
        wr(4'd3, 32'h01);
        rd(4'd4, r); check("R6 ack clears", r, 32'h0);

        // R5 falling edge
        wr(4'd0, 32'd6);
        pins[0] = 1'b1;
        @(negedge clk);
        rd(4'd4, r); check("R5 fall ignores rise", r, 32'h0);
        pins[0] = 1'b0;
        @(negedge clk);
        rd(4'd4, r); check("R5 fall latch", r, 32'h1);
        wr(4'd3, 32'h01);

        // R5 any edge
        wr(4'd0, 32'd7);
        pins[0] = 1'b1;
        @(negedge clk);
        rd(4'd4, r); check("R5 any rise", r, 32'h1);
        wr(4'd3, 32'h01);
        rd(4'd4, r); check("R6 ack any", r, 32'h0);
        pins[0] = 1'b0;
        @(negedge clk);
        rd(4'd4, r); check("R5 any fall", r, 32'h1);
        wr(4'd3, 32'h01);

        // R6 edge in same cycle as acknowledge wins
        @(negedge clk);
        pins[0] = 1'b1; wr_en = 1'b1; addr = 4'd3; wdata = 32'h01;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
        rd(4'd4, r); check("R6 edge beats ack", r, 32'h1);

        // R4 level high: ack has no lasting effect
        wr(4'd0, 32'd1);
        @(negedge clk);
        wr(4'd3, 32'h01);
        rd(4'd4, r); check("R4 level survives ack", r, 32'h1);
        pins[0] = 1'b0;
        @(negedge clk);
        rd(4'd4, r); check("R4 level follows pin", r, 32'h0);

        // R8 / R9 masking with groups 0 and 1 forced set
        wr(4'd2, 32'h0);
        wr(4'd0, 32'h1B);
        @(negedge clk);
        rd(4'd4, r); check("R7 set mode raw", r, 32'h3);
        rd(4'd5, r); check("R8 masked zero", r, 32'h0);
        check("R9 irq masked off", {31'b0, irq_o}, 32'h0);
        wr(4'd2, 32'h2);
        rd(4'd5, r); check("R8 masked and", r, 32'h2);
        check("R9 irq one cycle late", {31'b0, irq_o}, 32'h0);
        @(negedge clk);
        check("R9 irq asserted", {31'b0, irq_o}, 32'h1);

        // R10 undefined addresses
        wr(4'd7, 32'hFFFF_FFFF);
        wr(4'd4, 32'hFFFF_FFFF);
        rd(4'd0, r); check("R10 trig untouched", r, 32'h1B);
        rd(4'd2, r); check("R10 mask untouched", r, 32'h2);
        rd(4'd7, r); check("R10 undef read", r, 32'h0);
        rd(4'd3, r); check("R10 ack read", r, 32'h0);
        rd(4'd6, r); check("R10 addr6 read", r, 32'h0);

        done = 1;
        finish_run();
    end

endmodule